// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner

This block refreshes a row of eight common-cathode seven-segment digits. The digits are driven by two serial-in, parallel-out shift registers wired in a chain. The serial output of the first register feeds the data input of the second. Each register has its own output latch, and the latch clock is shared between them. The block owns three wires: one serial data line, one shift clock and one latch clock.

For every digit the block first sends a one-hot byte that selects the digit, and then the byte that lights its segments. It then pulses the latch clock once, so both registers update their outputs together. It holds that digit for a fixed dwell time before it starts the next digit. After the eighth digit it returns to the first.

The eight segment patterns arrive as one parallel 64-bit word. The block reads the pattern of a digit once, at the moment that digit's frame begins. Timing is set in system clock cycles: `HALF_CYC` is the length of each half of the shift-clock period and of the latch pulse, and `DWELL_CYC` is the hold time (for example, 1 ms worth of clocks).

Top module: `seven_seg_scanner`

## Requirements
- R1: While reset is asserted, shiftClk is low, latchClk is high and serData is low.
- R2: Each digit frame shifts exactly 16 bits, MSB first: the select byte first, then the segment byte. After the latch, the second register in the chain holds the select byte and the first register holds the segment byte.
- R3: serData changes only while shiftClk is low, and it is stable at every rising edge of shiftClk.
- R4: Exactly one latch pulse follows the 16th rising shift edge of a frame. latchClk is low for HALF_CYC cycles, and it is high at all other times.
- R5: The select byte is one-hot. Digit 0 takes patterns[63:56] and uses select 0x80. Each later digit k takes the next lower byte, patterns[63-8k -: 8], with the select bit moved one place right, down to digit 7 with patterns[7:0] and select 0x01.
- R6: After digit 7 the scan wraps to digit 0 (select 0x80).
- R7: The segment byte is sent unchanged: segments a to g in bits 6 to 0, and bit 7 carried through (for example 0x7F shows an 8 and 0x30 shows a 1).
- R8: The shift clock is low for HALF_CYC cycles and then high for HALF_CYC cycles per bit.
- R9: Consecutive latch rising edges are exactly 1 + 33·HALF_CYC + DWELL_CYC cycles apart. This is the dwell of DWELL_CYC cycles plus the next frame.
- R10: patterns is sampled only in the first cycle of a digit frame. A change later in the frame does not alter the bytes shifted for that digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| patterns | input | 64 | Eight segment bytes, digit 0 in the top byte |
| serData | output | 1 | Serial data into the first shift register |
| shiftClk | output | 1 | Shift clock shared by both registers, idles low |
| latchClk | output | 1 | Latch clock shared by both registers, idles high |

## Verification
A stuck or skipped state in the sequencer shows up at the next latch rise. Such a fault gives a rising-shift count other than 16, a latch-to-latch interval other than the computed period, or a latch pulse of the wrong width, so it is caught within one frame. A wrong digit counter or a bad byte ordering leaves the wrong bytes in the modelled register latches, and the scoreboard flags it on the same latch edge. Sampling the patterns late is exposed by inverting the pattern word partway through every frame.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

  localparam int NUM_DIGITS  = 8;
  localparam int SEG_W       = 8;
  localparam int SEL_W       = NUM_DIGITS;
  localparam int FRAME_BITS  = SEL_W + SEG_W;
  localparam int PATTERN_W   = NUM_DIGITS * SEG_W;
  localparam int DIGIT_IDX_W = $clog2(NUM_DIGITS);
  localparam int BIT_IDX_W   = $clog2(FRAME_BITS);

  typedef enum logic [2:0] {
    ST_LOAD,
    ST_SHIFT_LO,
    ST_SHIFT_HI,
    ST_LATCH_LO,
    ST_DWELL
  } scanState_t;

  // strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic                   loadFrame;
    logic                   shiftNext;
    logic [DIGIT_IDX_W-1:0] digitIdx;
  } scanStrobes_t;

endpackage

// File: rtl/seg_scan_ctrl.sv
module seg_scan_ctrl
  import seg_scan_pkg::*;
#(
  parameter int HALF_CYC  = 4,
  parameter int DWELL_CYC = 50000
) (
  input  logic         clk,
  input  logic         rst,
  output scanStrobes_t strobes,
  output logic         shiftClk,
  output logic         latchClk
);

  localparam int TIMER_MAX = (DWELL_CYC > HALF_CYC) ? DWELL_CYC : HALF_CYC;
  localparam int TIMER_W   = $clog2(TIMER_MAX + 1);
  localparam logic [TIMER_W-1:0]     HALF_LAST  = TIMER_W'(HALF_CYC - 1);
  localparam logic [TIMER_W-1:0]     DWELL_LAST = TIMER_W'(DWELL_CYC - 1);
  localparam logic [BIT_IDX_W-1:0]   BIT_LAST   = BIT_IDX_W'(FRAME_BITS - 1);
  localparam logic [DIGIT_IDX_W-1:0] DIGIT_LAST = DIGIT_IDX_W'(NUM_DIGITS - 1);

  scanState_t             state;
  logic [TIMER_W-1:0]     timer;
  logic [BIT_IDX_W-1:0]   bitCnt;
  logic [DIGIT_IDX_W-1:0] digitIdx;
  logic                   halfDone;
  logic                   dwellDone;

  assign halfDone  = (timer == HALF_LAST);
  assign dwellDone = (timer == DWELL_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_LOAD;
      timer    <= '0;
      bitCnt   <= '0;
      digitIdx <= '0;
    end else begin
      case (state)
        ST_LOAD: begin
          state  <= ST_SHIFT_LO;
          timer  <= '0;
          bitCnt <= '0;
        end
        ST_SHIFT_LO: begin
          if (halfDone) begin
            state <= ST_SHIFT_HI;
            timer <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_SHIFT_HI: begin
          if (halfDone) begin
            timer <= '0;
            if (bitCnt == BIT_LAST) begin
              state <= ST_LATCH_LO;
            end else begin
              bitCnt <= bitCnt + 1'b1;
              state  <= ST_SHIFT_LO;
            end
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_LATCH_LO: begin
          if (halfDone) begin
            state <= ST_DWELL;
            timer <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_DWELL: begin
          if (dwellDone) begin
            state    <= ST_LOAD;
            timer    <= '0;
            digitIdx <= (digitIdx == DIGIT_LAST) ? '0 : digitIdx + 1'b1;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: begin
          state <= ST_LOAD;
          timer <= '0;
        end
      endcase
    end
  end

  always_comb begin
    strobes.loadFrame = (state == ST_LOAD);
    strobes.shiftNext = (state == ST_SHIFT_HI) && halfDone && (bitCnt != BIT_LAST);
    strobes.digitIdx  = digitIdx;
  end

  assign shiftClk = (state == ST_SHIFT_HI);
  assign latchClk = (state != ST_LATCH_LO);

  // R4: latch only goes low once the whole frame has been shifted
  p_latch_after_frame_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(latchClk) |-> (bitCnt == BIT_LAST));

  // R6: the digit after the last one is the first one
  p_digit_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DWELL && dwellDone && digitIdx == DIGIT_LAST) |=> (digitIdx == '0));

  // R8: shift clock never stays high past one half period
  p_shift_high_r8: assert property (@(posedge clk) disable iff (rst)
    (shiftClk && halfDone) |=> !shiftClk);

endmodule

// File: rtl/seg_scan_dp.sv
module seg_scan_dp
  import seg_scan_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  scanStrobes_t         strobes,
  input  logic [PATTERN_W-1:0] patterns,
  output logic                 serData
);

  logic [SEG_W-1:0]      digitBytes [NUM_DIGITS];
  logic [SEL_W-1:0]      selByte;
  logic [FRAME_BITS-1:0] frameWord;

  // digit 0 sits in the top byte of the pattern word
  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_unpack
    assign digitBytes[g] = patterns[(NUM_DIGITS - 1 - g) * SEG_W +: SEG_W];
  end

  assign selByte = SEL_W'(1) << (NUM_DIGITS - 1 - int'(strobes.digitIdx));

  always_ff @(posedge clk) begin
    if (rst) begin
      frameWord <= '0;
    end else if (strobes.loadFrame) begin
      frameWord <= {selByte, digitBytes[strobes.digitIdx]};
    end else if (strobes.shiftNext) begin
      frameWord <= {frameWord[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign serData = frameWord[FRAME_BITS-1];

  // R5: a freshly loaded frame carries exactly one select bit
  p_onehot_sel_r5: assert property (@(posedge clk) disable iff (rst)
    strobes.loadFrame |=> ($countones(frameWord[FRAME_BITS-1 -: SEL_W]) == 1));

endmodule

// File: rtl/seven_seg_scanner.sv
module seven_seg_scanner
  import seg_scan_pkg::*;
#(
  parameter int HALF_CYC  = 4,
  parameter int DWELL_CYC = 50000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [63:0] patterns,
  output logic        serData,
  output logic        shiftClk,
  output logic        latchClk
);

  scanStrobes_t strobes;

  seg_scan_ctrl #(
    .HALF_CYC (HALF_CYC),
    .DWELL_CYC(DWELL_CYC)
  ) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .shiftClk(shiftClk),
    .latchClk(latchClk)
  );

  seg_scan_dp i_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .patterns(patterns),
    .serData (serData)
  );

  // R3: data must not move on the edge the registers capture it
  p_data_stable_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(shiftClk) |-> $stable(serData));

endmodule

// File: tb/test_seven_seg_scanner.sv
module test_seven_seg_scanner;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int DWELL      = 40;
  localparam int PERIOD     = 1 + 33 * HALF + DWELL;
  localparam int FRAMES     = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] patterns = '0;
  logic        serData, shiftClk, latchClk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit ended  = 1'b0;
  logic [15:0] expQ [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  seven_seg_scanner #(.HALF_CYC(HALF), .DWELL_CYC(DWELL)) i_seven_seg_scanner (
    .clk(clk), .rst(rst), .patterns(patterns),
    .serData(serData), .shiftClk(shiftClk), .latchClk(latchClk)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [7:0] segFor(int f, int d);
    logic [7:0] showCodes [8] = '{8'h7F, 8'h70, 8'h5F, 8'h5B, 8'h33, 8'h79, 8'h6D, 8'h30};
    if (f < 8) return showCodes[d];
    return 8'((f * 37 + d * 11) ^ 8'hA5);
  endfunction

  function automatic logic [63:0] wordFor(int f);
    logic [63:0] w;
    for (int d = 0; d < 8; d++) w[63 - 8 * d -: 8] = segFor(f, d);
    return w;
  endfunction

  function automatic logic [15:0] expFor(int f);
    int d = f % 8;
    return {8'h80 >> d, segFor(f, d)};
  endfunction

  // driver: sets the pattern before each frame start and disturbs it mid-frame
  initial begin
    patterns = wordFor(0);
    repeat (3) @(negedge clk);
    check(shiftClk == 1'b0, "R1", "shiftClk in reset", int'(shiftClk), 0);
    check(latchClk == 1'b1, "R1", "latchClk in reset", int'(latchClk), 1);
    check(serData == 1'b0, "R1", "serData in reset", int'(serData), 0);
    expQ.push_back(expFor(0));
    rst = 1'b0;
    for (int f = 0; f < FRAMES; f++) begin
      repeat (10) @(negedge clk);
      patterns = ~patterns;                       // R10 disturbance
      repeat (PERIOD - 10) @(negedge clk);
      if (f + 1 < FRAMES) begin
        patterns = wordFor(f + 1);
        expQ.push_back(expFor(f + 1));
      end
    end
    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R9", "frames left unlatched", expQ.size(), 0);
    done = 1'b1;
    finishRun();
  end

  // monitor: model of the two chained shift registers and their latches
  logic [7:0] sr1, sr2, q1, q2;
  logic       prevS, prevL, prevD;
  int         cycle, hiRun, loRun, shiftRises, lastRise, frameNo;

  always @(negedge clk) begin
    if (rst) begin
      prevS = 1'b0; prevL = 1'b1; prevD = 1'b0;
      sr1 = '0; sr2 = '0; q1 = '0; q2 = '0;
      cycle = 0; hiRun = 0; loRun = 0; shiftRises = 0; lastRise = -1; frameNo = 0;
    end else begin
      cycle++;
      if (shiftClk && !prevS) begin
        check(serData == prevD, "R3", "serData moved at shift edge", int'(serData), int'(prevD));
        sr2 = {sr2[6:0], sr1[7]};
        sr1 = {sr1[6:0], serData};
        shiftRises++;
        check(latchClk == 1'b1, "R4", "latch low while shifting", int'(latchClk), 1);
      end
      if (shiftClk) hiRun++;
      if (!shiftClk && prevS) begin
        check(hiRun == HALF, "R8", "shift clock high width", hiRun, HALF);
        hiRun = 0;
      end
      if (!latchClk) loRun++;
      if (latchClk && !prevL) begin
        check(loRun == HALF, "R4", "latch low width", loRun, HALF);
        check(shiftRises == 16, "R2", "shift edges per frame", shiftRises, 16);
        loRun = 0;
        shiftRises = 0;
        q1 = sr1;
        q2 = sr2;
        if (lastRise >= 0)
          check(cycle - lastRise == PERIOD, "R9", "latch-to-latch period", cycle - lastRise, PERIOD);
        lastRise = cycle;
        if (expQ.size() == 0) begin
          check(1'b0, "R4", "unexpected latch pulse", int'(q2), 0);
        end else begin
          automatic logic [15:0] e = expQ.pop_front();
          if (frameNo >= 8 && frameNo % 8 == 0)
            check(q2 == e[15:8], "R6", "select after wrap", int'(q2), int'(e[15:8]));
          else
            check(q2 == e[15:8], "R5", "digit select byte", int'(q2), int'(e[15:8]));
          check(q1 == e[7:0], "R7", "segment byte", int'(q1), int'(e[7:0]));
          check(q1 == e[7:0], "R10", "segment byte sampled at frame start", int'(q1), int'(e[7:0]));
          check({q2, q1} == e, "R2", "select then segment order", int'({q2, q1}), int'(e));
        end
        frameNo++;
      end
      prevS = shiftClk;
      prevL = latchClk;
      prevD = serData;
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    end
    finishRun();
  end

endmodule